// File: doc/BRIEF.md
# Eight-Input Interrupt Controller Core

This block gathers eight interrupt request lines into a single interrupt signal for a processor. It records incoming requests, lets software block single inputs, remembers which inputs are being served, and picks the winner by fixed priority. Input 0 has the highest priority. A request can interrupt the processor only if its level outranks every level that is currently in service.

The processor answers the interrupt with two acknowledge pulses. The first pulse moves the winning request into service. The second pulse returns a vector equal to a programmed base number plus the input's index. Software controls the block through one write port with four register addresses:

- address 0: trigger mode
- address 1: vector base
- address 2: mask
- address 3: command (end-of-interrupt and read-select)

A status output always shows either the request register or the in-service register, whichever was last selected.

Top module: `irqc_core`

## Requirements
- R1: After reset `int_req` and `vec_valid` are 0, `stat_out` shows the request register and reads 0, trigger mode is edge, the mask is 0 and the base is 0.
- R2: In edge mode (address 0, bit 0 = 0) a request bit is set only by a 0-to-1 change on its input. An input that stays high after its request is acknowledged does not set the bit again.
- R3: In level mode (address 0, bit 0 = 1) each request bit follows its input one cycle later, and an acknowledge does not clear it.
- R4: A mask bit of 1 (address 2, bit n for input n) keeps that input from raising `int_req`. The request is still recorded in the request register, and clearing the mask bit releases it.
- R5: `int_req` is 1 when the lowest-numbered pending unmasked request has a lower index than every set in-service bit (or no in-service bit is set). Otherwise it is 0.
- R6: On the first acknowledge pulse the winner's in-service bit is set, and in edge mode its request bit is cleared.
- R7: On the second acknowledge pulse `vec_out` becomes base + winner index, and `vec_valid` is 1 for exactly the following cycle.
- R8: Command byte with bits [7:6] = 01 (non-specific end of interrupt) clears the lowest-numbered set in-service bit.
- R9: Command byte with bits [7:6] = 10 (specific end of interrupt) clears the in-service bit whose index is in bits [2:0].
- R10: Command byte with bits [7:6] = 11 selects the status source: bit 0 = 1 selects the in-service register, bit 0 = 0 selects the request register.
- R11: A write to address 1 sets the vector base used by all later vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 8 | Interrupt request lines, index 0 highest |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 mode, 1 base, 2 mask, 3 command) |
| wr_data | input | 8 | Write data |
| ack | input | 1 | Acknowledge pulse from the processor |
| int_req | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector returned after the second acknowledge |
| vec_valid | output | 1 | Vector qualifier, one cycle |
| stat_out | output | 8 | Selected status register |

## Verification
Each result becomes visible at a known number of cycles after its stimulus:

- **Request bits, in-service bits, mask, base and status select:** one cycle after the input change or write, because each passes through one register stage.
- **`int_req`:** combinational from those registers, so it is due in the same cycle they change.
- **Vector:** registered once more after the second acknowledge, so it appears on the cycle that follows that pulse.

The bench drives inputs on falling edges and samples at the next falling edge, so every check falls exactly one rising edge after its stimulus. A monitor process pops expected vectors from a queue only when `vec_valid` is high.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   typedef enum logic [1:0] {
      ADR_MODE = 2'd0,
      ADR_BASE = 2'd1,
      ADR_MASK = 2'd2,
      ADR_CMD  = 2'd3
   } irqc_addr_e;

   typedef enum logic [1:0] {
      OP_NOP     = 2'd0,
      OP_EOI_ANY = 2'd1,
      OP_EOI_LVL = 2'd2,
      OP_RDSEL   = 2'd3
   } irqc_op_e;
endpackage

// File: rtl/irqc_req_bank.sv
module irqc_req_bank #(
   parameter int N_IRQ = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             level_mode,
   input  logic [N_IRQ-1:0] irq_in,
   input  logic [N_IRQ-1:0] clr,
   output logic [N_IRQ-1:0] irr
);
   logic [N_IRQ-1:0] prev_q;

   for (genvar i = 0; i < N_IRQ; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_q[i] <= 1'b0;
            irr[i]    <= 1'b0;
         end else begin
            prev_q[i] <= irq_in[i];
            if (level_mode) begin
               irr[i] <= irq_in[i];
            end else begin
               irr[i] <= (irr[i] & ~clr[i]) | (irq_in[i] & ~prev_q[i]);
            end
         end
      end
   end
endmodule

// File: rtl/irqc_resolver.sv
module irqc_resolver #(
   parameter int N_IRQ = 8,
   localparam int LW = $clog2(N_IRQ)
) (
   input  logic [N_IRQ-1:0] irr,
   input  logic [N_IRQ-1:0] mask,
   input  logic [N_IRQ-1:0] isr,
   output logic             grant,
   output logic [LW-1:0]    grant_lvl
);
   logic [N_IRQ-1:0] pend;
   logic [LW-1:0]    pend_lvl, isr_lvl;
   logic             pend_any, isr_any;

   assign pend = irr & ~mask;

   always_comb begin
      pend_any = 1'b0;
      pend_lvl = '0;
      isr_any  = 1'b0;
      isr_lvl  = '0;
      for (int i = N_IRQ - 1; i >= 0; i--) begin
         if (pend[i]) begin
            pend_any = 1'b1;
            pend_lvl = LW'(i);
         end
         if (isr[i]) begin
            isr_any = 1'b1;
            isr_lvl = LW'(i);
         end
      end
   end

   assign grant     = pend_any && (!isr_any || (pend_lvl < isr_lvl));
   assign grant_lvl = pend_lvl;
endmodule

// File: rtl/irqc_service.sv
module irqc_service #(
   parameter int N_IRQ = 8,
   localparam int LW = $clog2(N_IRQ)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_en,
   input  logic [LW-1:0]    set_lvl,
   input  logic             eoi_any,
   input  logic             eoi_one,
   input  logic [LW-1:0]    eoi_lvl,
   output logic [N_IRQ-1:0] isr
);
   logic [N_IRQ-1:0] set_vec, clr_any, clr_one;

   assign set_vec = set_en ? (N_IRQ'(1) << set_lvl) : '0;
   // lowest set bit isolates the highest priority level in service
   assign clr_any = eoi_any ? (isr & (~isr + N_IRQ'(1))) : '0;
   assign clr_one = eoi_one ? (N_IRQ'(1) << eoi_lvl) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) isr <= '0;
      else        isr <= (isr & ~(clr_any | clr_one)) | set_vec;
   end
endmodule

// File: rtl/irqc_core.sv
module irqc_core #(
   parameter int N_IRQ = 8,
   parameter int VEC_W = 8,
   localparam int LW = $clog2(N_IRQ)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_IRQ-1:0] irq_in,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [7:0]       wr_data,
   input  logic             ack,
   output logic             int_req,
   output logic [VEC_W-1:0] vec_out,
   output logic             vec_valid,
   output logic [N_IRQ-1:0] stat_out
);
   import irqc_pkg::*;

   if (N_IRQ < 2 || N_IRQ > 8 || (1 << LW) != N_IRQ) begin : g_bad_n
      $error("irqc_core: N_IRQ must be a power of two from 2 to 8");
   end
   if (VEC_W <= LW) begin : g_bad_w
      $error("irqc_core: VEC_W must exceed the level width");
   end

   logic             level_mode, rd_isr, ack_phase;
   logic [VEC_W-1:0] base_q;
   logic [N_IRQ-1:0] mask_q, irr, isr, irr_clr;
   logic [LW-1:0]    grant_lvl, ack_lvl;
   logic             grant, first_ack, second_ack;
   logic             cmd_wr, eoi_any, eoi_one;
   irqc_op_e         op;

   assign first_ack  = ack && !ack_phase;
   assign second_ack = ack && ack_phase;
   assign cmd_wr     = wr_en && (wr_addr == ADR_CMD);
   assign op         = irqc_op_e'(wr_data[7:6]);
   assign eoi_any    = cmd_wr && (op == OP_EOI_ANY);
   assign eoi_one    = cmd_wr && (op == OP_EOI_LVL);
   assign irr_clr    = (first_ack && grant) ? (N_IRQ'(1) << grant_lvl) : '0;

   irqc_req_bank #(.N_IRQ(N_IRQ)) u_req (
      .clk(clk), .rst_n(rst_n), .level_mode(level_mode),
      .irq_in(irq_in), .clr(irr_clr), .irr(irr)
   );

   irqc_resolver #(.N_IRQ(N_IRQ)) u_res (
      .irr(irr), .mask(mask_q), .isr(isr),
      .grant(grant), .grant_lvl(grant_lvl)
   );

   irqc_service #(.N_IRQ(N_IRQ)) u_svc (
      .clk(clk), .rst_n(rst_n),
      .set_en(first_ack && grant), .set_lvl(grant_lvl),
      .eoi_any(eoi_any), .eoi_one(eoi_one), .eoi_lvl(wr_data[LW-1:0]),
      .isr(isr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_mode <= 1'b0;
         base_q     <= '0;
         mask_q     <= '0;
         rd_isr     <= 1'b0;
      end else if (wr_en) begin
         unique case (irqc_addr_e'(wr_addr))
            ADR_MODE: level_mode <= wr_data[0];
            ADR_BASE: base_q     <= wr_data[VEC_W-1:0];
            ADR_MASK: mask_q     <= wr_data[N_IRQ-1:0];
            ADR_CMD:  if (op == OP_RDSEL) rd_isr <= wr_data[0];
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_phase <= 1'b0;
         ack_lvl   <= '0;
         vec_out   <= '0;
         vec_valid <= 1'b0;
      end else begin
         vec_valid <= 1'b0;
         if (first_ack) begin
            ack_phase <= 1'b1;
            ack_lvl   <= grant ? grant_lvl : LW'(N_IRQ - 1);
         end else if (second_ack) begin
            ack_phase <= 1'b0;
            vec_out   <= base_q + VEC_W'(ack_lvl);
            vec_valid <= 1'b1;
         end
      end
   end

   assign int_req  = grant;
   assign stat_out = rd_isr ? isr : irr;
endmodule

// File: rtl/irqc_core_chk.sv
module irqc_core_chk #(
   parameter int N_IRQ = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ack,
   input logic             ack_phase,
   input logic             int_req,
   input logic [N_IRQ-1:0] irr,
   input logic [N_IRQ-1:0] mask,
   input logic [N_IRQ-1:0] isr,
   input logic             vec_valid,
   input logic             wr_en,
   input logic [1:0]       wr_addr,
   input logic [7:0]       wr_data
);
   logic cmd_wr;
   assign cmd_wr = wr_en && (wr_addr == 2'd3);

   AST_INT_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      int_req |-> ((irr & ~mask) != '0)); // R4

   AST_ACK_ADDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !ack_phase && int_req && !cmd_wr)
      |=> ($countones(isr) == $past($countones(isr)) + 1)); // R6

   AST_VEC_AFTER_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> $past(ack && ack_phase)); // R7

   AST_VEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |=> !vec_valid); // R7

   AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && wr_data[7:6] == 2'b01 && isr != '0 && !(ack && !ack_phase))
      |=> ($countones(isr) == $past($countones(isr)) - 1)); // R8
endmodule

bind irqc_core irqc_core_chk #(.N_IRQ(N_IRQ)) u_chk (
   .clk(clk), .rst_n(rst_n), .ack(ack), .ack_phase(ack_phase),
   .int_req(int_req), .irr(irr), .mask(mask_q), .isr(isr),
   .vec_valid(vec_valid), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/irqc_core_test.sv
module irqc_core_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq_in = '0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       ack = 1'b0;
   logic       int_req, vec_valid;
   logic [7:0] vec_out, stat_out;

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;
   logic [7:0] exp_q[$];

   irqc_core uut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .ack(ack),
      .int_req(int_req), .vec_out(vec_out), .vec_valid(vec_valid),
      .stat_out(stat_out)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic ack1();
      ack = 1'b1; tick(); ack = 1'b0; tick();
   endtask

   task automatic ack2(input logic [7:0] exp_vec);
      exp_q.push_back(exp_vec);
      ack = 1'b1; tick(); ack = 1'b0; tick();
   endtask

   // monitor: compares produced vectors against the scoreboard queue (R7)
   always @(negedge clk) begin
      if (rst_n && vec_valid) begin
         if (exp_q.size() == 0) begin
            total++; fails++;
            $display("FAIL R7: actual %h expected none", vec_out);
         end else begin
            chk("R7 vector", vec_out, exp_q.pop_front());
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      chk("R1 int_req", {7'd0, int_req}, 8'h00);
      chk("R1 vec_valid", {7'd0, vec_valid}, 8'h00);
      chk("R1 stat", stat_out, 8'h00);

      wr(2'd1, 8'h40);                                  // R11 base
      irq_in[3] = 1'b1; tick();
      chk("R2 edge set", stat_out, 8'h08);
      chk("R5 int up", {7'd0, int_req}, 8'h01);
      ack1();
      chk("R6 request cleared", stat_out, 8'h00);
      chk("R5 self blocked", {7'd0, int_req}, 8'h00);
      ack2(8'h43);
      wr(2'd3, 8'hC1);
      chk("R10 isr read", stat_out, 8'h08);

      irq_in[5] = 1'b1; tick();
      chk("R5 lower blocked", {7'd0, int_req}, 8'h00);
      irq_in[1] = 1'b1; tick();
      chk("R5 higher nests", {7'd0, int_req}, 8'h01);
      ack1();
      chk("R6 nested isr", stat_out, 8'h0A);
      ack2(8'h41);
      wr(2'd3, 8'hC0);
      chk("R2 held input not reset", stat_out, 8'h20);
      wr(2'd3, 8'hC1);

      wr(2'd3, 8'h40);
      chk("R8 nonspecific eoi", stat_out, 8'h08);
      chk("R5 still blocked", {7'd0, int_req}, 8'h00);
      wr(2'd3, 8'h83);
      chk("R9 specific eoi", stat_out, 8'h00);
      chk("R5 released", {7'd0, int_req}, 8'h01);
      ack1();
      ack2(8'h45);
      wr(2'd3, 8'h85);
      chk("R9 specific eoi 5", stat_out, 8'h00);

      irq_in = '0; tick();
      wr(2'd2, 8'h04);
      irq_in[2] = 1'b1; tick();
      wr(2'd3, 8'hC0);
      chk("R4 masked recorded", stat_out, 8'h04);
      chk("R4 masked no int", {7'd0, int_req}, 8'h00);
      wr(2'd2, 8'h00);
      chk("R4 unmask", {7'd0, int_req}, 8'h01);
      ack1();
      ack2(8'h42);
      wr(2'd3, 8'h40);
      irq_in = '0; tick();

      wr(2'd0, 8'h01);
      irq_in[6] = 1'b1; tick();
      chk("R3 level follows high", stat_out, 8'h40);
      irq_in[6] = 1'b0; tick();
      chk("R3 level follows low", stat_out, 8'h00);
      chk("R3 no int", {7'd0, int_req}, 8'h00);
      irq_in[6] = 1'b1; tick();
      ack1();
      ack2(8'h46);
      chk("R3 ack keeps level", stat_out, 8'h40);
      wr(2'd1, 8'h80);
      wr(2'd3, 8'h40);
      chk("R3 reasserts", {7'd0, int_req}, 8'h01);
      ack1();
      ack2(8'h86);                                      // R11 new base
      tick();
      chk("R7 queue drained", 8'(exp_q.size()), 8'h00);

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule